// File: doc/BRIEF.md
# Annealed Stochastic Mask Generator

This block supplies an optimisation engine with one N-bit random mask per iteration. Every bit position has its own pseudo-random lane, and a bit is set when that lane's fresh byte falls below a shared probability threshold. The chance that a bit is set is therefore about threshold/256, and bits at different positions are independent of each other.

The threshold follows an annealing schedule. A `start` pulse latches a start threshold, an end threshold and a step count, reloads the schedule and reseeds every lane. Each later `step` pulse presents a new mask at the current threshold and then moves the threshold one step down a straight line toward the end value. The threshold holds at the end value once the step count is used up. A start value of 51 and an end value of 3 give a set probability that falls from about 20% to about 1%. Early iterations therefore mask broadly and later ones mask sparsely.

The current threshold is visible on `probLevel`. A mask appears on `mask` with a one-cycle `maskValid` strobe and stays unchanged until the next step.

Top module: `annealMaskGen`

## Requirements
- R1: Mask bit i is set exactly when lane i's current byte is below the threshold, so a threshold of 0 gives an all-zero mask.
- R2: At a constant threshold T, the fraction of set mask bits over many iterations is close to T/256. For T=51 this is about 20%, and for T=3 it is about 1%.
- R3: Lanes are seeded differently, so two bit positions agree in only about half the iterations at T=128.
- R4: After k steps since start, with k at most the step count S, `probLevel` equals start − floor(k·(start−end)/S). After S steps it holds at the end value.
- R5: If the end value is at or above the start value, `probLevel` stays at the start value. If S is 0, `probLevel` is the end value from the first mask on.
- R6: A `step` pulse gives a new mask and `maskValid` high in the next cycle, for that one cycle only. `mask` then holds until the next step.
- R7: `start` clears `mask` and `maskValid`, reloads the schedule and reseeds the lanes, so a repeated configuration gives the same mask sequence. When `start` and `step` are high in the same cycle, `start` wins and no mask is produced.
- R8: After reset, `mask`, `maskValid` and `probLevel` are 0, and `step` pulses are ignored until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch the configuration, restart the schedule and reseed the lanes |
| step | input | 1 | Produce a mask and advance the schedule |
| cfgStartThr | input | TW (8) | Threshold for the first mask |
| cfgEndThr | input | TW (8) | Final threshold |
| cfgSteps | input | SW (16) | Number of steps from the start threshold to the end threshold |
| mask | output | N (8) | Random mask, one bit per city |
| maskValid | output | 1 | One-cycle strobe marking a new mask |
| probLevel | output | TW (8) | Threshold the next mask will use |

## Verification
The bench builds the block with its defaults: 8 lanes, an 8-bit threshold and a 16-bit step count. Short step counts of 3 to 10 let the clamp at the end value, the schedule's rounding and the zero-count case all be reached within a few dozen cycles. A 100-step schedule shows the fractional accumulator holding the threshold flat for several steps. With 8 lanes, a few hundred iterations give 1,600 to 3,200 bit samples. That is enough to tell a 20% rate from a 1% rate and independent lanes from copied ones.

// File: rtl/annealMaskPkg.sv
package annealMaskPkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef struct packed {
    logic load;   // restart schedule, reseed lanes
    logic emit;   // capture a mask this cycle
    logic decay;  // move threshold one step toward end
  } maskStrobes_t;
endpackage

// File: rtl/annealMaskLane.sv
module annealMaskLane
  import annealMaskPkg::*;
#(
  parameter int TW = 8,
  parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reseed,
  input  logic          advance,
  input  logic [TW-1:0] thr,
  output logic          bitOut
);
  logic [LFSR_W-1:0] state;

  function automatic logic [LFSR_W-1:0] advanceBy(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] v;
    v = s;
    for (int b = 0; b < TW; b++) begin
      v = v[0] ? ((v >> 1) ^ LFSR_TAPS) : (v >> 1);
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEED;
    else if (reseed)  state <= SEED;
    else if (advance) state <= advanceBy(state);
  end

  assign bitOut = (state[TW-1:0] < thr);
endmodule

// File: rtl/annealMaskCtrl.sv
module annealMaskCtrl
  import annealMaskPkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          step,
  input  logic [SW-1:0] cfgSteps,
  output maskStrobes_t  strobes
);
  logic          running;
  logic [SW-1:0] stepCount;
  logic [SW-1:0] stepLimit;

  always_comb begin
    strobes.load  = start;
    strobes.emit  = step && running && !start;
    strobes.decay = strobes.emit && (stepCount < stepLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      stepCount <= '0;
      stepLimit <= '0;
    end else if (strobes.load) begin
      running   <= 1'b1;
      stepCount <= '0;
      stepLimit <= cfgSteps;
    end else if (strobes.decay) begin
      stepCount <= stepCount + 1'b1;
    end
  end
endmodule

// File: rtl/annealMaskPath.sv
module annealMaskPath
  import annealMaskPkg::*;
#(
  parameter int          N         = 8,
  parameter int          TW        = 8,
  parameter int          SW        = 16,
  parameter logic [31:0] SEED_BASE = 32'h0000_1D2C
) (
  input  logic          clk,
  input  logic          rstN,
  input  maskStrobes_t  strobes,
  input  logic [TW-1:0] cfgStartThr,
  input  logic [TW-1:0] cfgEndThr,
  input  logic [SW-1:0] cfgSteps,
  output logic [N-1:0]  mask,
  output logic          maskValid,
  output logic [TW-1:0] probLevel
);
  logic [TW-1:0] delta;
  logic [TW-1:0] wholeNext;
  logic [SW-1:0] fracNext;
  logic [TW-1:0] wholeR;
  logic [SW-1:0] fracR;
  logic [SW-1:0] stepsR;
  logic [SW-1:0] acc;
  logic [SW:0]   accSum;
  logic [N-1:0]  laneBits;

  // Per-step decrement = delta / steps, split into whole and remainder
  always_comb begin
    logic [SW:0] rem;
    delta     = (cfgStartThr > cfgEndThr) ? (cfgStartThr - cfgEndThr) : '0;
    rem       = '0;
    wholeNext = '0;
    for (int b = TW - 1; b >= 0; b--) begin
      rem = {rem[SW-1:0], delta[b]};
      if (cfgSteps != '0 && rem >= {1'b0, cfgSteps}) begin
        rem          = rem - {1'b0, cfgSteps};
        wholeNext[b] = 1'b1;
      end
    end
    fracNext = rem[SW-1:0];
  end

  assign accSum = {1'b0, acc} + {1'b0, fracR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      probLevel <= '0;
      wholeR    <= '0;
      fracR     <= '0;
      stepsR    <= '0;
      acc       <= '0;
    end else if (strobes.load) begin
      probLevel <= (cfgSteps == '0) ? cfgEndThr : cfgStartThr;
      wholeR    <= wholeNext;
      fracR     <= fracNext;
      stepsR    <= cfgSteps;
      acc       <= '0;
    end else if (strobes.decay) begin
      if (accSum >= {1'b0, stepsR}) begin
        acc       <= SW'(accSum - {1'b0, stepsR});
        probLevel <= probLevel - wholeR - 1'b1;
      end else begin
        acc       <= accSum[SW-1:0];
        probLevel <= probLevel - wholeR;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam logic [31:0] SEED_MIX = (SEED_BASE ^ (32'(i) * 32'd40503 + 32'd4321)) | 32'd1;
    annealMaskLane #(
      .TW  (TW),
      .SEED(SEED_MIX[LFSR_W-1:0])
    ) lane_i (
      .clk    (clk),
      .rstN   (rstN),
      .reseed (strobes.load),
      .advance(strobes.emit),
      .thr    (probLevel),
      .bitOut (laneBits[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask      <= '0;
      maskValid <= 1'b0;
    end else if (strobes.load) begin
      mask      <= '0;
      maskValid <= 1'b0;
    end else if (strobes.emit) begin
      mask      <= laneBits;
      maskValid <= 1'b1;
    end else begin
      maskValid <= 1'b0;
    end
  end
endmodule

// File: rtl/annealMaskGen.sv
module annealMaskGen
  import annealMaskPkg::*;
#(
  parameter int          N         = 8,
  parameter int          TW        = 8,
  parameter int          SW        = 16,
  parameter logic [31:0] SEED_BASE = 32'h0000_1D2C
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          step,
  input  logic [TW-1:0] cfgStartThr,
  input  logic [TW-1:0] cfgEndThr,
  input  logic [SW-1:0] cfgSteps,
  output logic [N-1:0]  mask,
  output logic          maskValid,
  output logic [TW-1:0] probLevel
);
  maskStrobes_t strobes;

  annealMaskCtrl #(.SW(SW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .step    (step),
    .cfgSteps(cfgSteps),
    .strobes (strobes)
  );

  annealMaskPath #(
    .N(N), .TW(TW), .SW(SW), .SEED_BASE(SEED_BASE)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgStartThr(cfgStartThr),
    .cfgEndThr  (cfgEndThr),
    .cfgSteps   (cfgSteps),
    .mask       (mask),
    .maskValid  (maskValid),
    .probLevel  (probLevel)
  );
endmodule

// File: rtl/annealMaskGenChk.sv
module annealMaskGenChk #(
  parameter int N  = 8,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          step,
  input logic [N-1:0]  mask,
  input logic          maskValid,
  input logic [TW-1:0] probLevel
);
  assert_valid_after_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    maskValid |-> ($past(step) && !$past(start)));

  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(step) && !$past(start)) |-> $stable(mask));

  assert_level_never_rises_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> (probLevel <= $past(probLevel)));

  assert_zero_level_empty_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    (probLevel == '0 && step && !start) |=> (mask == '0));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!maskValid && mask == '0));
endmodule

bind annealMaskGen annealMaskGenChk #(.N(N), .TW(TW)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .step(step),
  .mask(mask), .maskValid(maskValid), .probLevel(probLevel)
);

// File: tb/annealMaskGen_tb_top.sv
module annealMaskGen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int TW = 8;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          step = 1'b0;
  logic [TW-1:0] cfgStartThr = '0;
  logic [TW-1:0] cfgEndThr = '0;
  logic [SW-1:0] cfgSteps = '0;
  logic [N-1:0]  mask;
  logic          maskValid;
  logic [TW-1:0] probLevel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  annealMaskGen #(.N(N), .TW(TW), .SW(SW)) dut_i (.*);

  // {start, end, steps, k, expected level}
  localparam logic [47:0] VEC [10] = '{
    {8'd51,  8'd3,  16'd10,  8'd0,  8'd51},
    {8'd51,  8'd3,  16'd10,  8'd5,  8'd27},
    {8'd51,  8'd3,  16'd10,  8'd10, 8'd3},
    {8'd51,  8'd3,  16'd10,  8'd15, 8'd3},
    {8'd51,  8'd3,  16'd7,   8'd3,  8'd31},
    {8'd51,  8'd3,  16'd100, 8'd1,  8'd51},
    {8'd51,  8'd3,  16'd100, 8'd3,  8'd50},
    {8'd200, 8'd0,  16'd3,   8'd2,  8'd67},
    {8'd20,  8'd50, 16'd5,   8'd2,  8'd20},
    {8'd40,  8'd9,  16'd0,   8'd0,  8'd9}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doStart(input int s, input int e, input int n);
    @(negedge clk);
    cfgStartThr = TW'(s); cfgEndThr = TW'(e); cfgSteps = SW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic doStep(output logic [N-1:0] m, output logic v);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    m = mask;
    v = maskValid;
  endtask

  initial begin
    logic [N-1:0] m;
    logic v;
    logic [N-1:0] firstRun [4];
    int ones;
    int agree;

    repeat (3) @(negedge clk);
    // R8: reset state
    check(mask == '0 && !maskValid && probLevel == '0, "R8 reset state", int'(mask), 0);
    rstN = 1'b1;
    @(negedge clk);
    doStep(m, v);
    check(!v, "R8 step before start valid", int'(v), 0);
    check(m == '0, "R8 step before start mask", int'(m), 0);

    // R4/R5: schedule vector table
    foreach (VEC[idx]) begin
      doStart(int'(VEC[idx][47:40]), int'(VEC[idx][39:32]), int'(VEC[idx][31:16]));
      for (int k = 0; k < int'(VEC[idx][15:8]); k++) doStep(m, v);
      check(probLevel == VEC[idx][7:0],
            (idx >= 8) ? "R5 schedule level" : "R4 schedule level",
            int'(probLevel), int'(VEC[idx][7:0]));
    end

    // R6: valid pulse and mask hold
    doStart(128, 128, 4);
    doStep(m, v);
    check(v == 1'b1, "R6 valid after step", int'(v), 1);
    @(negedge clk);
    check(!maskValid, "R6 valid one cycle", int'(maskValid), 0);
    repeat (3) @(negedge clk);
    check(mask == m, "R6 mask holds", int'(mask), int'(m));

    // R7: repeatable after restart; start wins over step
    doStart(128, 128, 4);
    for (int i = 0; i < 4; i++) begin doStep(m, v); firstRun[i] = m; end
    doStart(128, 128, 4);
    for (int i = 0; i < 4; i++) begin
      doStep(m, v);
      check(m == firstRun[i], "R7 repeat sequence", int'(m), int'(firstRun[i]));
    end
    doStart(60, 0, 2);
    @(negedge clk);
    cfgStartThr = 8'd60; cfgEndThr = 8'd0; cfgSteps = 16'd2;
    start = 1'b1; step = 1'b1;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    check(!maskValid, "R7 start beats step valid", int'(maskValid), 0);
    check(probLevel == 8'd60, "R7 start beats step level", int'(probLevel), 60);

    // R1: zero threshold gives empty masks
    doStart(0, 0, 4);
    ones = 0;
    for (int i = 0; i < 20; i++) begin doStep(m, v); ones += $countones(m); end
    check(ones == 0, "R1 zero threshold", ones, 0);

    // R2: rate at 20% and at 1%
    doStart(51, 51, 1);
    ones = 0;
    for (int i = 0; i < 200; i++) begin doStep(m, v); ones += $countones(m); end
    check(ones >= 260 && ones <= 380, "R2 rate at 51", ones, 320);
    doStart(3, 3, 1);
    ones = 0;
    for (int i = 0; i < 200; i++) begin doStep(m, v); ones += $countones(m); end
    check(ones >= 3 && ones <= 45, "R2 rate at 3", ones, 19);

    // R3: lane independence at 50%
    doStart(128, 128, 1);
    agree = 0;
    for (int i = 0; i < 400; i++) begin doStep(m, v); if (m[0] == m[1]) agree++; end
    check(agree >= 150 && agree <= 250, "R3 lane agreement", agree, 200);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule